// File: doc/BRIEF.md
# Four-Path Rotating Zero-Suppressed Strip Readout

This block reads out a 128-channel strip front end without any trigger or readout request. Each channel gives a hit flag and a 3-bit amplitude code. A beam-crossing strobe marks the boundary between crossing periods. Four event paths take turns, and each path spends four consecutive crossings on one event. In the first crossing it is the capturing path. In the second its snapshot is reduced to at most four hit words. In the third and fourth its words go onto a single serial line. Because the paths are staggered by one crossing, one path is always capturing while older events are being reduced and shifted out.

A hit word is 12 bits, sent MSB first: a 2-bit path tag in bits 11:10, the 7-bit channel number in bits 9:3, and the amplitude in bits 2:0. The serial line has 24 fast clocks per crossing, so each crossing has two 12-bit word slots. In each slot, words still pending from the older serializing event go before words from the newer one. A word enable output is high while word bits are on the line. When no word is being sent, both outputs stay low.

Top module: `strip_push_readout`

## Requirements
- R1: After reset, the k-th strobe closes the capture period of path (k-1) mod 4. Every word from that event carries (k-1) mod 4 in bits 11:10. The capturing path advances by exactly one, wrapping 3 to 0, on each strobe and holds otherwise.
- R2: A word is 12 bits with the tag in bits 11:10, the channel in bits 9:3 and the amplitude in bits 2:0. It is sent MSB first, one bit per clock. ser_vld_o is high for exactly the bit clocks of whole words.
- R3: An event keeps only its four lowest-numbered hit channels. Its words go out in ascending channel order, and any further hits are discarded.
- R4: hit_i and amp_i are sampled only on the clock edge that registers the strobe. Values held earlier in the same crossing have no effect.
- R5: The event closed by strobe k is sent only in the crossings opened by strobes k+1 and k+2. Each crossing has two slots: the first bit of a slot word appears on the second or on the fourteenth clock after the strobe edge.
- R6: Each slot takes the next pending word of the older serializing event, or of the newer one if the older has none left. Words still unsent when an event's second serialize crossing ends are dropped.
- R7: An event with no hits sends nothing. Whenever ser_vld_o is low, ser_o is low.
- R8: Synchronous reset clears all paths and both outputs. The next event captured after reset is tagged path 0, and no word from before the reset is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous active-high reset |
| bco_i | input | 1 | One-clock strobe that starts each crossing, every BCO_LEN clocks |
| hit_i | input | NCH | Per-channel hit flags |
| amp_i | input | NCH*AW | Per-channel amplitude codes, channel c in bits c*AW +: AW |
| ser_o | output | 1 | Serial hit word stream, MSB first |
| ser_vld_o | output | 1 | High while word bits are on ser_o |

## Verification
The main stream is driven with a sequence of events: an empty one, a single hit, hits on channels 0 and 127 together, six scattered hits, a dense block, every channel hit, and back-to-back four-hit events. These patterns separate a wrong word layout or channel order, a wrong cut at four hits, and a wrong tag rotation. The dense events fill both slots of a crossing, so they show whether the older event goes first and whether leftover words are dropped rather than sent late. A second run resets the block in the middle of a stream and changes the inputs part-way through a crossing. This shows that nothing from before the reset leaks out and that only the value held at the strobe is captured.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int NPATH = 4;
  localparam int PW    = 2;
  localparam int MAXH  = 4;
  localparam int HIW   = 2;
  typedef logic [PW-1:0] path_t;
endpackage

// File: rtl/spr_sched.sv
module spr_sched
  import spr_pkg::*;
#(
  parameter int BCO_LEN = 24,
  parameter int CW      = $clog2(BCO_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bco_i,
  output path_t         cap_path,
  output logic [CW-1:0] cyc
);
  localparam logic [CW-1:0] CYC_END = CW'(BCO_LEN - 1);

  // cap_path: path capturing in the current crossing
  // cyc: clocks since the strobe edge, parked at the end value
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_path <= '0;
      cyc      <= CYC_END;
    end else if (bco_i) begin
      cap_path <= cap_path + path_t'(1);
      cyc      <= '0;
    end else if (cyc != CYC_END) begin
      cyc <= cyc + 1'b1;
    end
  end
endmodule

// File: rtl/spr_sparsify.sv
module spr_sparsify
  import spr_pkg::*;
#(
  parameter int NCH = 128,
  parameter int AW  = 3,
  parameter int CHW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bco_i,
  input  path_t                 cap_path,
  input  logic [NCH-1:0]        hit_i,
  input  logic [NCH*AW-1:0]     amp_i,
  output logic                  wr_en,
  output path_t                 wr_path,
  output logic [HIW-1:0]        wr_idx,
  output logic [PW+CHW+AW-1:0]  wr_word
);
  localparam logic [HIW:0] MAXN = (HIW+1)'(MAXH);

  logic [NCH-1:0]    mask_q;
  logic [NCH*AW-1:0] amp_q;
  path_t             path_q;
  logic [HIW:0]      n_q;
  logic [CHW-1:0]    lo;
  logic              found;

  // lowest set channel of the remaining mask
  always_comb begin
    lo = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_q[i]) lo = CHW'(i);
    end
    found = |mask_q;
  end

  assign wr_en   = found && (n_q < MAXN) && !bco_i;
  assign wr_path = path_q;
  assign wr_idx  = n_q[HIW-1:0];
  assign wr_word = {path_q, lo, amp_q[lo*AW +: AW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      path_q <= '0;
      n_q    <= '0;
    end else if (bco_i) begin
      mask_q <= hit_i;
      path_q <= cap_path;
      n_q    <= '0;
    end else if (wr_en) begin
      mask_q[lo] <= 1'b0;
      n_q        <= n_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bco_i) amp_q <= amp_i;
  end
endmodule

// File: rtl/spr_serializer.sv
module spr_serializer
  import spr_pkg::*;
#(
  parameter int CHW     = 7,
  parameter int AW      = 3,
  parameter int BCO_LEN = 24,
  parameter int CW      = $clog2(BCO_LEN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bco_i,
  input  path_t                 cap_path,
  input  logic [CW-1:0]         cyc,
  input  logic                  wr_en,
  input  path_t                 wr_path,
  input  logic [HIW-1:0]        wr_idx,
  input  logic [PW+CHW+AW-1:0]  wr_word,
  output logic                  ser_o,
  output logic                  ser_vld_o
);
  localparam int WW   = PW + CHW + AW;
  localparam int HALF = BCO_LEN / 2;
  localparam int BW   = $clog2(WW + 1);

  logic [WW-1:0] mem [NPATH*MAXH];
  logic [HIW:0]  cnt_q  [NPATH];
  logic [HIW:0]  sent_q [NPATH];
  logic [WW-1:0] sh_q;
  logic [BW-1:0] left_q;
  path_t         older, newer, sel;
  logic          any;
  logic          slot_go;
  logic [WW-1:0] rd_word;

  // word store, one row of MAXH words per path
  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_path, wr_idx}] <= wr_word;
  end

  assign older   = cap_path + path_t'(1);
  assign newer   = cap_path + path_t'(2);
  assign slot_go = (cyc == CW'(0)) || (cyc == CW'(HALF));

  always_comb begin
    any = 1'b1;
    sel = older;
    if (sent_q[older] < cnt_q[older]) sel = older;
    else if (sent_q[newer] < cnt_q[newer]) sel = newer;
    else any = 1'b0;
  end

  assign rd_word = mem[{sel, sent_q[sel][HIW-1:0]}];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPATH; p++) begin
        cnt_q[p]  <= '0;
        sent_q[p] <= '0;
      end
      sh_q      <= '0;
      left_q    <= '0;
      ser_o     <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      if (wr_en) cnt_q[wr_path] <= cnt_q[wr_path] + 1'b1;
      if (bco_i) begin
        cnt_q[cap_path]  <= '0;
        sent_q[cap_path] <= '0;
      end
      if (slot_go && any) begin
        sent_q[sel] <= sent_q[sel] + 1'b1;
        ser_o       <= rd_word[WW-1];
        sh_q        <= rd_word << 1;
        left_q      <= BW'(WW - 1);
        ser_vld_o   <= 1'b1;
      end else if (left_q != '0) begin
        ser_o     <= sh_q[WW-1];
        sh_q      <= sh_q << 1;
        left_q    <= left_q - 1'b1;
        ser_vld_o <= 1'b1;
      end else begin
        ser_o     <= 1'b0;
        ser_vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/strip_push_readout.sv
module strip_push_readout
  import spr_pkg::*;
#(
  parameter int NCH     = 128,
  parameter int AW      = 3,
  parameter int BCO_LEN = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bco_i,
  input  logic [NCH-1:0]    hit_i,
  input  logic [NCH*AW-1:0] amp_i,
  output logic              ser_o,
  output logic              ser_vld_o
);
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(BCO_LEN);
  localparam int WW  = PW + CHW + AW;

  path_t          cap_path;
  logic [CW-1:0]  cyc;
  logic           wr_en;
  path_t          wr_path;
  logic [HIW-1:0] wr_idx;
  logic [WW-1:0]  wr_word;

  spr_sched #(.BCO_LEN(BCO_LEN), .CW(CW)) u_sched (
    .clk(clk), .rst(rst), .bco_i(bco_i), .cap_path(cap_path), .cyc(cyc)
  );

  spr_sparsify #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_sparsify (
    .clk(clk), .rst(rst), .bco_i(bco_i), .cap_path(cap_path),
    .hit_i(hit_i), .amp_i(amp_i), .wr_en(wr_en), .wr_path(wr_path),
    .wr_idx(wr_idx), .wr_word(wr_word)
  );

  spr_serializer #(.CHW(CHW), .AW(AW), .BCO_LEN(BCO_LEN), .CW(CW)) u_serializer (
    .clk(clk), .rst(rst), .bco_i(bco_i), .cap_path(cap_path), .cyc(cyc),
    .wr_en(wr_en), .wr_path(wr_path), .wr_idx(wr_idx), .wr_word(wr_word),
    .ser_o(ser_o), .ser_vld_o(ser_vld_o)
  );
endmodule

// File: rtl/spr_checker.sv
module spr_checker
  import spr_pkg::*;
#(
  parameter int BCO_LEN = 24,
  parameter int CW      = 5,
  parameter int WW      = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          bco_i,
  input path_t         ph,
  input logic [CW-1:0] cyc,
  input logic          ser_o,
  input logic          ser_vld_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (ser_vld_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    bco_i |=> (ph == $past(ph) + path_t'(1)));

  // R1
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bco_i |=> $stable(ph));

  // R2
  word_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_vld_o) |-> ((run_q % WW) == 0));

  // R5
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_vld_o) |-> ($past(cyc) == CW'(0) || $past(cyc) == CW'(BCO_LEN/2)));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_vld_o |-> !ser_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ser_vld_o && !ser_o));
endmodule

bind strip_push_readout spr_checker #(.BCO_LEN(BCO_LEN), .CW(CW), .WW(WW)) u_spr_chk (
  .clk(clk), .rst(rst), .bco_i(bco_i), .ph(cap_path), .cyc(cyc),
  .ser_o(ser_o), .ser_vld_o(ser_vld_o)
);

// File: tb/strip_push_readout_bench.sv
module strip_push_readout_bench;
  localparam int NCH     = 128;
  localparam int AW      = 3;
  localparam int BCO_LEN = 24;
  localparam int WW      = 12;
  localparam int NE      = 10;
  localparam int NS      = NE + 3;

  // stimulus vectors: hit pattern per event
  localparam logic [NCH-1:0] EV [NE] = '{
    128'd0,
    128'h20,
    {1'b1, 126'd0, 1'b1},
    (128'd1 << 3) | (128'd1 << 10) | (128'd1 << 20) | (128'd1 << 30) | (128'd1 << 40) | (128'd1 << 50),
    128'hF << 100,
    128'd0,
    {NCH{1'b1}},
    128'd3 << 64,
    128'hF << 8,
    128'hF << 20
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bco_i = 1'b0;
  logic [NCH-1:0] hit_i = '0;
  logic [NCH*AW-1:0] amp_i = '0;
  logic ser_o, ser_vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  int bco_n = 0;
  int nb = 0;
  int ng = 0;
  int start_b = 0;
  int idle_bad = 0;
  logic [WW-1:0] acc = '0;
  logic [WW-1:0] got_w [64];
  int got_b [64];
  logic [WW-1:0] exp_w [64];
  int exp_b [64];
  int n_exp = 0;

  strip_push_readout #(.NCH(NCH), .AW(AW), .BCO_LEN(BCO_LEN)) u_strip_push_readout (
    .clk(clk), .rst(rst), .bco_i(bco_i), .hit_i(hit_i), .amp_i(amp_i),
    .ser_o(ser_o), .ser_vld_o(ser_vld_o)
  );

  always #5 clk = ~clk;

  // word collector
  always @(negedge clk) begin
    if (rst) begin
      nb = 0;
    end else begin
      if (!ser_vld_o && ser_o) idle_bad++;
      if (ser_vld_o) begin
        if (nb == 0) start_b = bco_n;
        acc = {acc[WW-2:0], ser_o};
        nb++;
        if (nb == WW) begin
          if (ng < 64) begin
            got_w[ng] = acc;
            got_b[ng] = start_b;
          end
          ng++;
          nb = 0;
        end
      end
    end
  end

  function automatic logic [AW-1:0] amp_of(int c, int k);
    return AW'((c + 5 * k) & 7);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [NCH-1:0] h, int k);
    hit_i = h;
    for (int c = 0; c < NCH; c++) amp_i[c*AW +: AW] = amp_of(c, k);
  endtask

  task automatic strobe_w(int k, int nwait);
    repeat (nwait) @(negedge clk);
    bco_i = 1'b1;
    bco_n = k;
    @(negedge clk);
    bco_i = 1'b0;
  endtask

  task automatic strobe(int k);
    strobe_w(k, BCO_LEN - 1);
  endtask

  // expected stream from the requirements: keep, tag, slot order, drop
  task automatic build_exp();
    logic [WW-1:0] ew [NS+1][4];
    int en [NS+1];
    int sent [NS+1];
    logic [NCH-1:0] ev;
    n_exp = 0;
    for (int k = 0; k <= NS; k++) begin
      en[k] = 0;
      sent[k] = 0;
    end
    for (int k = 1; k <= NS; k++) begin
      ev = (k <= NE) ? EV[k-1] : '0;
      for (int c = 0; c < NCH; c++) begin
        if (ev[c] && en[k] < 4) begin
          ew[k][en[k]] = {2'((k - 1) % 4), 7'(c), amp_of(c, k)};
          en[k]++;
        end
      end
    end
    for (int b = 2; b <= NS; b++) begin
      for (int s = 0; s < 2; s++) begin
        if (b - 2 >= 1 && sent[b-2] < en[b-2]) begin
          exp_w[n_exp] = ew[b-2][sent[b-2]];
          exp_b[n_exp] = b;
          sent[b-2]++;
          n_exp++;
        end else if (sent[b-1] < en[b-1]) begin
          exp_w[n_exp] = ew[b-1][sent[b-1]];
          exp_b[n_exp] = b;
          sent[b-1]++;
          n_exp++;
        end
      end
    end
  endtask

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    build_exp();
    repeat (3) @(negedge clk);
    chk("R8", "ser_o in reset", ser_o, 0);
    chk("R8", "ser_vld_o in reset", ser_vld_o, 0);
    rst = 1'b0;

    // vector walk
    for (int k = 1; k <= NS; k++) begin
      drive((k <= NE) ? EV[k-1] : '0, k);
      strobe(k);
    end
    repeat (BCO_LEN + 4) @(negedge clk);
    chk("R3 R6", "word count", ng, n_exp);
    for (int i = 0; i < n_exp && i < ng; i++) begin
      chk("R1 R2 R3", "word", got_w[i], exp_w[i]);
      chk("R5 R6", "crossing", got_b[i], exp_b[i]);
    end

    // reset in the middle of a stream
    drive({NCH{1'b1}}, 1);
    strobe(1);
    drive('0, 2);
    strobe(2);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8", "ser_o after reset edge", ser_o, 0);
    chk("R8", "ser_vld_o after reset edge", ser_vld_o, 0);
    @(negedge clk);
    ng = 0;
    bco_n = 0;
    rst = 1'b0;

    // R4: early values replaced before the strobe
    drive(128'd1 << 7, 1);
    strobe(1);
    drive(128'hE, 2);
    repeat (10) @(negedge clk);
    drive(128'd1 << 120, 2);
    strobe_w(2, BCO_LEN - 11);
    for (int k = 3; k <= 5; k++) begin
      drive('0, k);
      strobe(k);
    end
    repeat (BCO_LEN + 4) @(negedge clk);
    chk("R8", "words after reset", ng, 2);
    chk("R8", "first word tag path 0", got_w[0], {2'd0, 7'd7, amp_of(7, 1)});
    chk("R5", "first word crossing", got_b[0], 2);
    chk("R4", "word from strobe-time inputs", got_w[1], {2'd1, 7'd120, amp_of(120, 2)});
    chk("R5", "second word crossing", got_b[1], 3);
    chk("R7", "bits while idle", idle_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule